// File: doc/BRIEF.md
# Quadword Bit-Field Extract/Insert Unit

This block works on the low 64-bit lane of a 128-bit vector register. It performs one of two field operations. Extract moves a field of the destination quadword down to bit 0 and clears every bit above the field. Insert writes the low bits of the source quadword into the destination quadword at a chosen bit offset and leaves the other destination bits as they were.

The field length and bit offset come from one of two places. In immediate form they come from two 8-bit immediates. In register form they come from fixed byte lanes of the 128-bit source operand. The upper 64 bits of the destination vector pass through unchanged.

One operation is accepted on each cycle that `in_valid` is high. The result is registered and appears one cycle later, with `out_valid` high.

Top module: `bfx_unit`

## Requirements
- R1: The field mask is (2^len − 1) for a nonzero 6-bit length len. A length of 0 selects a mask with all 64 bits set.
- R2: Extract (`op_insert`=0) returns (destination low quadword >> index) AND mask.
- R3: Insert (`op_insert`=1) returns the destination low quadword with (mask << index) cleared, ORed with ((source low quadword AND mask) << index).
- R4: In immediate form (`use_reg`=0), `imm_len[5:0]` is the length and `imm_idx[5:0]` is the index. Bits 7:6 of both immediates have no effect.
- R5: Register-form extract takes the length from `src_vec[5:0]` (byte 0) and the index from `src_vec[13:8]` (byte 1). The other bits of those bytes are ignored.
- R6: Register-form insert takes the length from `src_vec[69:64]` (byte 8) and the index from `src_vec[77:72]` (byte 9). The other bits of those bytes are ignored.
- R7: Field bits that would land above bit 63 are dropped. For extract, bits above 63 that are shifted down read as zero.
- R8: `out_hi` equals `dst_vec[127:64]` of the accepted operation.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_lo` and `out_hi` hold their values when `in_valid` is low.
- R10: While `rst_n` is low, `out_valid`, `out_lo` and `out_hi` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept an operation this cycle |
| op_insert | input | 1 | 0 = extract, 1 = insert |
| use_reg | input | 1 | 0 = immediate controls, 1 = controls from src_vec byte lanes |
| dst_vec | input | 128 | Destination vector; low lane is the operand or base |
| src_vec | input | 128 | Source vector; low lane is the insert data, bytes hold the register-form controls |
| imm_len | input | 8 | Immediate field length |
| imm_idx | input | 8 | Immediate bit index |
| out_valid | output | 1 | Result valid |
| out_lo | output | 64 | New low quadword |
| out_hi | output | 64 | Upper quadword passed through |

## Verification
The bench aims at the following corner cases. If a zero length were treated as an empty mask, a length-0 operation would return 0 or leave the destination untouched; the bench instead expects a full 64-bit field. Index 63 and index-plus-length combinations above 64 test whether the design drops the high field bits; a design that let them wrap would corrupt the low bits. Register-form tests fill the unused upper bits of the control bytes and swap the byte lanes between extract and insert, so reading the wrong lane or skipping the 6-bit reduction gives a wrong field. Hold cycles with changed inputs show whether the output register takes new data without `in_valid`.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  parameter int LANE_W = 64;
  parameter int VEC_W  = 2 * LANE_W;
  parameter int CTL_W  = $clog2(LANE_W);
  parameter int IMM_W  = 8;

  // byte lanes of the second operand holding register-form controls
  parameter int EXT_LEN_BYTE = 0;
  parameter int EXT_IDX_BYTE = 1;
  parameter int INS_LEN_BYTE = 8;
  parameter int INS_IDX_BYTE = 9;

  typedef logic [CTL_W-1:0] ctl_t;

  typedef struct packed {
    ctl_t len;
    ctl_t idx;
  } ctl_pair_t;
endpackage

// File: rtl/bfx_ctl_sel.sv
module bfx_ctl_sel
  import bfx_pkg::*;
#(
  parameter int VW = VEC_W,
  parameter int CW = CTL_W,
  parameter int IW = IMM_W
) (
  input  logic          op_insert,
  input  logic          use_reg,
  input  logic [VW-1:0] src_vec,
  input  logic [IW-1:0] imm_len,
  input  logic [IW-1:0] imm_idx,
  output ctl_pair_t     ctl
);
  localparam int EL = 8 * EXT_LEN_BYTE;
  localparam int EI = 8 * EXT_IDX_BYTE;
  localparam int NL = 8 * INS_LEN_BYTE;
  localparam int NI = 8 * INS_IDX_BYTE;

  logic unused_sel_bits;
  assign unused_sel_bits = ^{src_vec, imm_len, imm_idx};

  always_comb begin
    if (!use_reg) begin
      ctl.len = imm_len[CW-1:0];
      ctl.idx = imm_idx[CW-1:0];
    end else if (op_insert) begin
      ctl.len = src_vec[NL +: CW];
      ctl.idx = src_vec[NI +: CW];
    end else begin
      ctl.len = src_vec[EL +: CW];
      ctl.idx = src_vec[EI +: CW];
    end
  end
endmodule

// File: rtl/bfx_mask_gen.sv
module bfx_mask_gen
  import bfx_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int CW = CTL_W
) (
  input  logic [CW-1:0] len,
  output logic [LW-1:0] mask
);
  logic len_zero;
  assign len_zero = (len == '0);

  for (genvar i = 0; i < LW; i++) begin : g_bit
    assign mask[i] = len_zero | (CW'(i) < len);
  end
endmodule

// File: rtl/bfx_core.sv
module bfx_core
  import bfx_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int CW = CTL_W
) (
  input  logic          op_insert,
  input  logic [LW-1:0] base_lo,
  input  logic [LW-1:0] data_lo,
  input  logic [LW-1:0] mask,
  input  logic [CW-1:0] idx,
  output logic [LW-1:0] result
);
  logic [LW-1:0] ext_val;
  logic [LW-1:0] hole;
  logic [LW-1:0] field;
  logic [LW-1:0] ins_val;

  // left shifts at lane width drop anything past the top bit
  assign ext_val = (base_lo >> idx) & mask;
  assign hole    = mask << idx;
  assign field   = (data_lo & mask) << idx;

  for (genvar b = 0; b < LW; b++) begin : g_merge
    assign ins_val[b] = hole[b] ? field[b] : base_lo[b];
  end

  assign result = op_insert ? ins_val : ext_val;
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int IW = IMM_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            op_insert,
  input  logic            use_reg,
  input  logic [2*LW-1:0] dst_vec,
  input  logic [2*LW-1:0] src_vec,
  input  logic [IW-1:0]   imm_len,
  input  logic [IW-1:0]   imm_idx,
  output logic            out_valid,
  output logic [LW-1:0]   out_lo,
  output logic [LW-1:0]   out_hi
);
  localparam int VW = 2 * LW;
  localparam int CW = $clog2(LW);

  ctl_pair_t   ctl;
  logic [LW-1:0] mask;
  logic [LW-1:0] res_lo;

  logic          valid_d;
  logic [LW-1:0] lo_d;
  logic [LW-1:0] hi_d;

  bfx_ctl_sel #(.VW(VW), .CW(CW), .IW(IW)) u_sel (
    .op_insert (op_insert),
    .use_reg   (use_reg),
    .src_vec   (src_vec),
    .imm_len   (imm_len),
    .imm_idx   (imm_idx),
    .ctl       (ctl)
  );

  bfx_mask_gen #(.LW(LW), .CW(CW)) u_mask (
    .len  (ctl.len),
    .mask (mask)
  );

  bfx_core #(.LW(LW), .CW(CW)) u_core (
    .op_insert (op_insert),
    .base_lo   (dst_vec[LW-1:0]),
    .data_lo   (src_vec[LW-1:0]),
    .mask      (mask),
    .idx       (ctl.idx),
    .result    (res_lo)
  );

  // next state, data enabled by in_valid
  always_comb begin
    valid_d = in_valid;
    lo_d    = out_lo;
    hi_d    = out_hi;
    if (in_valid) begin
      lo_d = res_lo;
      hi_d = dst_vec[VW-1:LW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_lo    <= '0;
      out_hi    <= '0;
    end else begin
      out_valid <= valid_d;
      out_lo    <= lo_d;
      out_hi    <= hi_d;
    end
  end
endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk #(
  parameter int LW = 64,
  parameter int IW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            op_insert,
  input logic            use_reg,
  input logic [2*LW-1:0] dst_vec,
  input logic [IW-1:0]   imm_len,
  input logic [IW-1:0]   imm_idx,
  input logic            out_valid,
  input logic [LW-1:0]   out_lo,
  input logic [LW-1:0]   out_hi
);
  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_lo) && $stable(out_hi)));

  p_upper_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_hi == $past(dst_vec[2*LW-1:LW])));

  p_extract_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_insert && !use_reg && (imm_len[5:0] != 6'd0))
    |=> ((out_lo >> $past(imm_len[5:0])) == '0));

  p_insert_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_insert && !use_reg && (imm_idx[5:0] != 6'd0))
    |=> (out_lo[0] == $past(dst_vec[0])));

  always_comb begin
    if (!rst_n) begin
      p_reset_r10: assert (!out_valid || $isunknown(out_valid));
    end
  end
endmodule

bind bfx_unit bfx_unit_chk #(.LW(LW), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_insert (op_insert),
  .use_reg   (use_reg),
  .dst_vec   (dst_vec),
  .imm_len   (imm_len),
  .imm_idx   (imm_idx),
  .out_valid (out_valid),
  .out_lo    (out_lo),
  .out_hi    (out_hi)
);

// File: tb/sim_bfx_unit.sv
`timescale 1ns/1ps
module sim_bfx_unit;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         op_insert;
  logic         use_reg;
  logic [127:0] dst_vec;
  logic [127:0] src_vec;
  logic [7:0]   imm_len;
  logic [7:0]   imm_idx;
  logic         out_valid;
  logic [63:0]  out_lo;
  logic [63:0]  out_hi;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  bfx_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_insert(op_insert),
    .use_reg(use_reg), .dst_vec(dst_vec), .src_vec(src_vec),
    .imm_len(imm_len), .imm_idx(imm_idx), .out_valid(out_valid),
    .out_lo(out_lo), .out_hi(out_hi)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // bit-serial reference built from the requirement text
  function automatic logic [63:0] ref_model(input bit ins, input bit rg,
      input logic [127:0] d, input logic [127:0] s, input logic [7:0] il, input logic [7:0] ii);
    int len, idx, span;
    logic [63:0] r;
    if (!rg) begin len = int'(il[5:0]); idx = int'(ii[5:0]); end
    else if (ins) begin len = int'(s[69:64]); idx = int'(s[77:72]); end
    else begin len = int'(s[5:0]); idx = int'(s[13:8]); end
    span = (len == 0) ? 64 : len;
    if (!ins) begin
      r = '0;
      for (int b = 0; b < 64; b++)
        if (b < span && b + idx < 64) r[b] = d[b + idx];
    end else begin
      r = d[63:0];
      for (int b = 0; b < 64; b++)
        if (b >= idx && b - idx < span) r[b] = s[b - idx];
    end
    return r;
  endfunction

  // drive at negedge, sample at the next negedge (one register)
  task automatic run_op(input string req, input bit ins, input bit rg,
      input logic [127:0] d, input logic [127:0] s, input logic [7:0] il, input logic [7:0] ii);
    logic [63:0] exp;
    exp = ref_model(ins, rg, d, s, il, ii);
    op_insert = ins; use_reg = rg; dst_vec = d; src_vec = s;
    imm_len = il; imm_idx = ii; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, out_lo, exp);
    check("R8 upper lane", out_hi, d[127:64]);
    check("R9 out_valid", {63'd0, out_valid}, 64'd1);
  endtask

  task automatic t_reset;
    check("R10 reset valid", {63'd0, out_valid}, 64'd0);
    check("R10 reset lo", out_lo, 64'd0);
    check("R10 reset hi", out_hi, 64'd0);
  endtask

  task automatic t_mask;
    run_op("R1 extract len0 full mask", 0, 0, {64'hA5A5_0000_FFFF_1234, 64'hDEAD_BEEF_0123_4567}, '0, 8'd0, 8'd0);
    run_op("R1 extract len1", 0, 0, {64'h1, 64'hFFFF_FFFF_FFFF_FFFF}, '0, 8'd1, 8'd0);
    run_op("R1 insert len0 idx0 replaces whole lane", 1, 0, {64'h2, 64'h1111_2222_3333_4444}, {64'h0, 64'h8765_4321_0FED_CBA9}, 8'd0, 8'd0);
  endtask

  task automatic t_extract;
    run_op("R2 extract mid field", 0, 0, {64'h3, 64'h0123_4567_89AB_CDEF}, '0, 8'd12, 8'd20);
    run_op("R2 extract idx63", 0, 0, {64'h4, 64'h8000_0000_0000_0001}, '0, 8'd5, 8'd63);
  endtask

  task automatic t_insert;
    run_op("R3 insert mid field", 1, 0, {64'h5, 64'hFFFF_FFFF_FFFF_FFFF}, {64'h0, 64'h0000_0000_0000_0A5A}, 8'd12, 8'd8);
    run_op("R3 insert idx63 len1", 1, 0, {64'h6, 64'h0}, {64'h0, 64'h1}, 8'd1, 8'd63);
  endtask

  task automatic t_imm_upper_bits;
    run_op("R4 imm upper bits ignored extract", 0, 0, {64'h7, 64'hF0F0_1234_5678_9ABC}, '0, 8'hC8, 8'h84);
    run_op("R4 imm upper bits ignored insert", 1, 0, {64'h8, 64'h0}, {64'h0, 64'hFF}, 8'h44, 8'hC3);
  endtask

  task automatic t_reg_forms;
    // control bytes carry junk in bits 7:6 and the other lane holds decoys
    run_op("R5 reg extract bytes 0/1", 0, 1, {64'h9, 64'hCAFE_F00D_1357_9BDF},
           {64'h0000_0000_0000_1F07, 64'h0000_0000_0000_C4C8}, 8'd2, 8'd1);
    run_op("R6 reg insert bytes 8/9", 1, 1, {64'hA, 64'h0},
           {64'h0000_0000_0000_C8C6, 64'h0000_0000_0000_2F05}, 8'd3, 8'd1);
  endtask

  task automatic t_overflow;
    run_op("R7 insert past bit63 dropped", 1, 0, {64'hB, 64'h0000_0000_0000_00FF}, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, 8'd16, 8'd56);
    run_op("R7 insert len0 idx32", 1, 0, {64'hC, 64'h1234_5678_9ABC_DEF0}, {64'h0, 64'hFFFF_FFFF_0000_0001}, 8'd0, 8'd32);
    run_op("R7 extract len0 idx40 zero fill", 0, 0, {64'hD, 64'hFFFF_FFFF_FFFF_FFFF}, '0, 8'd0, 8'd40);
  endtask

  task automatic t_hold;
    logic [63:0] lo_before, hi_before;
    run_op("R2 extract before hold", 0, 0, {64'hE, 64'h7777_6666_5555_4444}, '0, 8'd8, 8'd4);
    lo_before = out_lo; hi_before = out_hi;
    dst_vec = {64'hBAD0_BAD0_BAD0_BAD0, 64'h1}; imm_len = 8'd3; op_insert = 1'b1;
    @(negedge clk);
    check("R9 valid low without strobe", {63'd0, out_valid}, 64'd0);
    check("R9 lo held", out_lo, lo_before);
    check("R9 hi held", out_hi, hi_before);
  endtask

  task automatic t_random;
    for (int k = 0; k < 60; k++) begin
      logic [127:0] d, s;
      d = {$urandom, $urandom, $urandom, $urandom};
      s = {$urandom, $urandom, $urandom, $urandom};
      run_op((k % 2) ? "R3 random" : "R2 random", bit'($urandom % 2), bit'($urandom % 2),
             d, s, 8'($urandom), 8'($urandom));
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_insert = 1'b0; use_reg = 1'b0;
    dst_vec = '0; src_vec = '0; imm_len = '0; imm_idx = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_mask();
    t_extract();
    t_insert();
    t_imm_upper_bits();
    t_reg_forms();
    t_overflow();
    t_hold();
    t_random();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule